// File: doc/BRIEF.md
# Physical memory protection configuration register bank

This block holds the control state for a 16-region memory protection unit on a 32-bit core. Each region has an 8-bit configuration byte (permission bits, address-match mode and a lock bit) and a 32-bit address register. A small guard register carries three global controls: a lockdown mode, a deny-by-default policy and a lock-bypass bit. The core's CSR path presents a register select, an index, write data and a write enable; four configuration bytes share one configuration register.

Every write is filtered before it reaches storage. Locked regions refuse changes. A locked top-of-range region also shields the address register of the region below it. Lockdown mode replaces the plain lock rule with a check on the written byte. The write-without-read permission combination is scrubbed when lockdown is off. The lockdown and deny-default bits cannot be cleared once set. The lock-bypass bit cannot be raised while anything is locked.

Read data is registered. When a write really changes stored state, the block raises `cfg_changed` for one cycle. Downstream logic uses that pulse to rebuild region bounds and drop cached translations.

Top module: `prot_csr_bank`

## Requirements
- R1: After reset, every configuration byte, address register and guard bit reads as zero, and `cfg_changed` is low.
- R2: A configuration write with `csr_sel`=0 and index n writes data byte i (bits 8i+7:8i) to region 4n+i, for i from 0 to 3. A read returns those four bytes packed the same way. Byte layout: bit 0 read, bit 1 write, bit 2 execute, bits 4:3 match mode (01 = top-of-range), bit 7 lock.
- R3: An address write with `csr_sel`=1 and index n stores all 32 data bits in region n. Any read returns, on the cycle after the request, the value held in the request cycle.
- R4: With lock-bypass clear and lockdown clear, a configuration write to a region whose lock bit is 1 leaves its byte unchanged. The other regions in the same write are still updated.
- R5: With lockdown set and lock-bypass clear, a configuration byte is accepted only when it has lock=1 and execute=0, or when it has lock=0 and its bits 2:0 are not 110. This rule applies whatever the stored lock bit is.
- R6: With lockdown clear, an accepted byte with write=1 and read=0 is stored with bits 1:0 cleared. With lockdown set, it is stored as written.
- R7: An address write to region n is ignored when region n is locked. It is also ignored when region n+1 is locked and in top-of-range mode.
- R8: Guard register (`csr_sel`=2): bit 0 is lockdown, bit 1 is deny-default, bit 2 is lock-bypass, and other bits read zero. Lockdown and deny-default stay set until reset once written to 1.
- R9: While lock-bypass is set, no region counts as locked. Lock-bypass cannot go from 0 to 1 while any region has its lock bit set.
- R10: A configuration region index of 16 or more, or an address index of 16 or more, reads as zero and ignores writes. `csr_sel`=3 reads zero.
- R11: `cfg_changed` is high for exactly the one cycle after a write that alters stored state. Writes that are rejected or that store an identical value do not raise it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| csr_sel | input | 2 | 0 configuration, 1 address, 2 guard, 3 none |
| csr_idx | input | 5 | Register index |
| csr_we | input | 1 | Write enable |
| csr_wdata | input | 32 | Write data |
| csr_rdata | output | 32 | Registered read data |
| cfg_changed | output | 1 | One-cycle pulse after a state-changing write |

## Verification
A wrongly accepted or rejected write shows up at the ports in two places. `cfg_changed` is wrong in the very next cycle. The stored value is wrong on the following read, one cycle after that read is requested. Because of this, the bench follows every write with a read-back of the affected register. It drives each filter path with values that sit just inside and just outside the acceptance rules: locked against unlocked, top-of-range against other modes, lockdown on against off, and lock-bypass on against off. A stuck or lost sticky guard bit appears on the next guard register read.

// File: rtl/prot_csr_pkg.sv
package prot_csr_pkg;
  typedef enum logic [1:0] {
    SEL_CFG  = 2'b00,
    SEL_ADDR = 2'b01,
    SEL_SEC  = 2'b10,
    SEL_NONE = 2'b11
  } csr_sel_e;

  localparam int BIT_R = 0;
  localparam int BIT_W = 1;
  localparam int BIT_X = 2;
  localparam int MODE_LO = 3;
  localparam int MODE_HI = 4;
  localparam int BIT_L = 7;
  localparam logic [1:0] MODE_TOP = 2'b01;

  localparam int SEC_LOCKDOWN = 0;
  localparam int SEC_DENY = 1;
  localparam int SEC_BYPASS = 2;

  // Acceptance decision for one configuration byte.
  function automatic logic cfg_accept(input logic [7:0] nb, input logic stored_l,
                                      input logic bypass, input logic lockdown);
    logic ok;
    if (bypass) ok = 1'b1;
    else if (!lockdown) ok = !stored_l;
    else ok = (nb[BIT_L] && !nb[BIT_X]) || (!nb[BIT_L] && (nb[2:0] != 3'b110));
    return ok;
  endfunction

  // Scrub the write-only permission pattern outside lockdown.
  function automatic logic [7:0] cfg_scrub(input logic [7:0] nb, input logic lockdown);
    logic [7:0] r;
    r = nb;
    if (!lockdown && nb[BIT_W] && !nb[BIT_R]) r[1:0] = 2'b00;
    return r;
  endfunction
endpackage

// File: rtl/prot_cfg_entry.sv
module prot_cfg_entry
  import prot_csr_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_hit,
  input  logic [7:0] wr_byte,
  input  logic       bypass,
  input  logic       lockdown,
  output logic [7:0] cfg,
  output logic       locked,
  output logic       changed
);
  logic [7:0] cfg_q;
  logic [7:0] cand;
  logic       accept;

  always_comb begin
    accept  = cfg_accept(wr_byte, cfg_q[BIT_L], bypass, lockdown);
    cand    = cfg_scrub(wr_byte, lockdown);
    changed = wr_hit && accept && (cand != cfg_q);
  end

  always_ff @(posedge clk) begin
    if (rst) cfg_q <= '0;
    else if (changed) cfg_q <= cand;
  end

  assign cfg    = cfg_q;
  assign locked = cfg_q[BIT_L] && !bypass;

  assert_locked_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (!bypass && !lockdown && cfg_q[BIT_L]) |=> $stable(cfg_q))
    else $error("locked byte changed");

  assert_lockdown_reject_R5: assert property (@(posedge clk) disable iff (rst)
    (wr_hit && lockdown && !bypass && !wr_byte[BIT_L] && wr_byte[2:0] == 3'b110)
      |=> $stable(cfg_q))
    else $error("rejected lockdown byte stored");

  assert_no_write_only_R6: assert property (@(posedge clk) disable iff (rst)
    !lockdown |-> !(cfg_q[BIT_W] && !cfg_q[BIT_R]))
    else $error("write-only pattern stored outside lockdown");
endmodule

// File: rtl/prot_sec_reg.sv
module prot_sec_reg
  import prot_csr_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       wr,
  input  logic [2:0] wr_bits,
  input  logic       any_lbit,
  output logic       lockdown,
  output logic       deny,
  output logic       bypass,
  output logic       changed
);
  logic ld_q, dn_q, bp_q;
  logic ld_n, dn_n, bp_n;

  always_comb begin
    ld_n = ld_q | wr_bits[SEC_LOCKDOWN];
    dn_n = dn_q | wr_bits[SEC_DENY];
    bp_n = wr_bits[SEC_BYPASS] && !(!bp_q && any_lbit);
    changed = wr && ({ld_n, dn_n, bp_n} != {ld_q, dn_q, bp_q});
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ld_q <= 1'b0;
      dn_q <= 1'b0;
      bp_q <= 1'b0;
    end else if (changed) begin
      ld_q <= ld_n;
      dn_q <= dn_n;
      bp_q <= bp_n;
    end
  end

  assign lockdown = ld_q;
  assign deny     = dn_q;
  assign bypass   = bp_q;

  assert_lockdown_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    ld_q |=> ld_q) else $error("lockdown cleared");
  assert_deny_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    dn_q |=> dn_q) else $error("deny-default cleared");
  assert_bypass_gate_R9: assert property (@(posedge clk) disable iff (rst)
    (!bp_q && any_lbit) |=> !bp_q) else $error("bypass raised over a lock");
endmodule

// File: rtl/prot_addr_bank.sv
module prot_addr_bank #(
  parameter int NUM_ENT = 16,
  parameter int XLEN    = 32,
  parameter int IDX_W   = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr,
  input  logic [IDX_W-1:0] idx,
  input  logic [XLEN-1:0]  wr_data,
  input  logic [NUM_ENT-1:0] locked,
  input  logic [NUM_ENT-1:0] top_mode,
  output logic [XLEN-1:0]  rd_val,
  output logic             changed
);
  localparam int ENT_W = (NUM_ENT > 1) ? $clog2(NUM_ENT) : 1;

  logic [XLEN-1:0]    addr_q [NUM_ENT];
  logic [NUM_ENT-1:0] blk;
  logic [ENT_W-1:0]   ent;
  logic               in_rng;

  for (genvar k = 0; k < NUM_ENT; k++) begin : g_blk
    if (k + 1 < NUM_ENT) begin : g_mid
      assign blk[k] = locked[k] | (locked[k+1] & top_mode[k+1]);
    end else begin : g_last
      assign blk[k] = locked[k];
    end
  end

  assign ent    = idx[ENT_W-1:0];
  assign in_rng = int'(idx) < NUM_ENT;

  always_comb begin
    changed = 1'b0;
    rd_val  = '0;
    if (in_rng) begin
      changed = wr && !blk[ent] && (addr_q[ent] != wr_data);
      rd_val  = addr_q[ent];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < NUM_ENT; k++) addr_q[k] <= '0;
    end else if (changed) begin
      addr_q[ent] <= wr_data;
    end
  end

  for (genvar k = 0; k < NUM_ENT; k++) begin : g_chk
    assert_addr_hold_R7: assert property (@(posedge clk) disable iff (rst)
      blk[k] |=> $stable(addr_q[k])) else $error("blocked address changed");
  end
endmodule

// File: rtl/prot_csr_bank.sv
module prot_csr_bank
  import prot_csr_pkg::*;
#(
  parameter int NUM_ENT = 16,
  parameter int XLEN    = 32,
  parameter int IDX_W   = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       csr_sel,
  input  logic [IDX_W-1:0] csr_idx,
  input  logic             csr_we,
  input  logic [XLEN-1:0]  csr_wdata,
  output logic [XLEN-1:0]  csr_rdata,
  output logic             cfg_changed
);
  localparam int BYTES = XLEN / 8;
  localparam int ENT_W = (NUM_ENT > 1) ? $clog2(NUM_ENT) : 1;

  csr_sel_e sel;
  logic [7:0]         cfg_arr [NUM_ENT];
  logic [8*NUM_ENT-1:0] cfg_pack;
  logic [NUM_ENT-1:0] lock_vec, lbit_vec, top_vec, cfg_chg;
  logic lockdown, deny, bypass, sec_chg, addr_chg;
  logic cfg_wr;
  logic [XLEN-1:0] addr_rd, rd_next, rd_q;
  logic mod_q;

  assign sel    = csr_sel_e'(csr_sel);
  assign cfg_wr = csr_we && (sel == SEL_CFG);

  for (genvar k = 0; k < NUM_ENT; k++) begin : g_ent
    prot_cfg_entry u_ent (
      .clk     (clk),
      .rst     (rst),
      .wr_hit  (cfg_wr && (int'(csr_idx) == k / BYTES)),
      .wr_byte (csr_wdata[8*(k%BYTES) +: 8]),
      .bypass  (bypass),
      .lockdown(lockdown),
      .cfg     (cfg_arr[k]),
      .locked  (lock_vec[k]),
      .changed (cfg_chg[k])
    );
    assign lbit_vec[k] = cfg_arr[k][BIT_L];
    assign top_vec[k]  = cfg_arr[k][MODE_HI:MODE_LO] == MODE_TOP;
    assign cfg_pack[8*k +: 8] = cfg_arr[k];
  end

  prot_sec_reg u_sec (
    .clk     (clk),
    .rst     (rst),
    .wr      (csr_we && (sel == SEL_SEC)),
    .wr_bits (csr_wdata[2:0]),
    .any_lbit(|lbit_vec),
    .lockdown(lockdown),
    .deny    (deny),
    .bypass  (bypass),
    .changed (sec_chg)
  );

  prot_addr_bank #(.NUM_ENT(NUM_ENT), .XLEN(XLEN), .IDX_W(IDX_W)) u_addr (
    .clk     (clk),
    .rst     (rst),
    .wr      (csr_we && (sel == SEL_ADDR)),
    .idx     (csr_idx),
    .wr_data (csr_wdata),
    .locked  (lock_vec),
    .top_mode(top_vec),
    .rd_val  (addr_rd),
    .changed (addr_chg)
  );

  always_comb begin
    int e;
    rd_next = '0;
    e = 0;
    unique case (sel)
      SEL_CFG: begin
        for (int i = 0; i < BYTES; i++) begin
          e = int'(csr_idx) * BYTES + i;
          if (e < NUM_ENT) rd_next[8*i +: 8] = cfg_arr[e[ENT_W-1:0]];
        end
      end
      SEL_ADDR: rd_next = addr_rd;
      SEL_SEC: begin
        rd_next[SEC_LOCKDOWN] = lockdown;
        rd_next[SEC_DENY]     = deny;
        rd_next[SEC_BYPASS]   = bypass;
      end
      default: rd_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_q  <= '0;
      mod_q <= 1'b0;
    end else begin
      rd_q  <= rd_next;
      mod_q <= (|cfg_chg) | sec_chg | addr_chg;
    end
  end

  assign csr_rdata   = rd_q;
  assign cfg_changed = mod_q;

  assert_mod_on_change_R11: assert property (@(posedge clk) disable iff (rst)
    (cfg_pack != $past(cfg_pack)) |-> mod_q)
    else $error("configuration changed without pulse");

  assert_mod_idle_R11: assert property (@(posedge clk) disable iff (rst)
    !csr_we |=> !mod_q) else $error("pulse without write");

  assert_cfg_oor_R10: assert property (@(posedge clk) disable iff (rst)
    (cfg_wr && int'(csr_idx) * BYTES >= NUM_ENT) |=> $stable(cfg_pack))
    else $error("out-of-range configuration write stored");
endmodule

// File: tb/test_prot_csr_bank.sv
module test_prot_csr_bank;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  csr_sel = 2'd3;
  logic [4:0]  csr_idx = '0;
  logic        csr_we = 1'b0;
  logic [31:0] csr_wdata = '0;
  logic [31:0] csr_rdata;
  logic        cfg_changed;

  int checks = 0;
  int errors = 0;

  logic [7:0]  m_cfg [16];
  logic [31:0] m_addr [16];
  bit m_ld, m_dn, m_bp;

  always #5 clk = ~clk;

  prot_csr_bank i_prot_csr_bank (
    .clk(clk), .rst(rst), .csr_sel(csr_sel), .csr_idx(csr_idx),
    .csr_we(csr_we), .csr_wdata(csr_wdata), .csr_rdata(csr_rdata),
    .cfg_changed(cfg_changed)
  );

  function automatic bit m_locked(int k);
    return !m_bp && m_cfg[k][7];
  endfunction

  task automatic model_clear();
    for (int k = 0; k < 16; k++) begin
      m_cfg[k] = '0;
      m_addr[k] = '0;
    end
    m_ld = 0; m_dn = 0; m_bp = 0;
  endtask

  task automatic model_step(input int sel, input int idx, input bit wr,
                            input logic [31:0] d, output logic [31:0] rd,
                            output bit chg);
    rd = '0;
    chg = 0;
    case (sel)
      0: for (int i = 0; i < 4; i++) if (idx*4 + i < 16) rd[8*i +: 8] = m_cfg[idx*4 + i];
      1: if (idx < 16) rd = m_addr[idx];
      2: rd = {29'd0, m_bp, m_dn, m_ld};
      default: rd = '0;
    endcase
    if (!wr) return;
    if (sel == 0) begin
      for (int i = 0; i < 4; i++) begin
        int e;
        logic [7:0] b;
        bit ok;
        e = idx*4 + i;
        if (e >= 16) continue;
        b = d[8*i +: 8];
        if (m_bp) ok = 1;
        else if (m_ld) ok = (b[7] && !b[2]) || (!b[7] && b[2:0] != 3'b110);
        else ok = !m_cfg[e][7];
        if (!m_ld && b[1] && !b[0]) b[1:0] = 2'b00;
        if (ok && b != m_cfg[e]) begin
          m_cfg[e] = b;
          chg = 1;
        end
      end
    end else if (sel == 1) begin
      if (idx < 16) begin
        bit blocked;
        blocked = m_locked(idx);
        if (idx < 15 && m_locked(idx+1) && m_cfg[idx+1][4:3] == 2'b01) blocked = 1;
        if (!blocked && d != m_addr[idx]) begin
          m_addr[idx] = d;
          chg = 1;
        end
      end
    end else if (sel == 2) begin
      bit nl, nd, nb, anyl;
      anyl = 0;
      for (int k = 0; k < 16; k++) if (m_cfg[k][7]) anyl = 1;
      nl = m_ld | d[0];
      nd = m_dn | d[1];
      nb = d[2] && !(!m_bp && anyl);
      if ({nl, nd, nb} != {m_ld, m_dn, m_bp}) chg = 1;
      m_ld = nl; m_dn = nd; m_bp = nb;
    end
  endtask

  // One operation per clock; compared at the following falling edge.
  task automatic op(input int sel, input int idx, input bit wr,
                    input logic [31:0] d, input string tag);
    logic [31:0] rd_exp;
    bit chg_exp;
    csr_sel = 2'(sel);
    csr_idx = 5'(idx);
    csr_we = wr;
    csr_wdata = d;
    model_step(sel, idx, wr, d, rd_exp, chg_exp);
    @(negedge clk);
    checks++;
    if (csr_rdata !== rd_exp) begin
      errors++;
      $display("FAIL %s csr_rdata actual %h expected %h", tag, csr_rdata, rd_exp);
    end
    checks++;
    if (cfg_changed !== chg_exp) begin
      errors++;
      $display("FAIL %s cfg_changed actual %b expected %b", tag, cfg_changed, chg_exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    csr_sel = 2'd3;
    csr_we = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    model_clear();
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog expired actual running expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    model_clear();
    @(negedge clk);
    do_reset();
    // R1 reset values
    op(0, 0, 0, 0, "R1");
    op(1, 0, 0, 0, "R1");
    op(2, 0, 0, 0, "R1");
    // R2 packing, R6 write-only scrub
    op(0, 0, 1, 32'h070D0219, "R2");
    op(0, 0, 0, 0, "R2_R6");
    // R3 address write/read, R11 identical write
    op(1, 5, 1, 32'h12345678, "R3");
    op(1, 5, 0, 0, "R3");
    op(1, 5, 1, 32'h12345678, "R11");
    op(1, 5, 0, 0, "R11");
    // R4 locking
    op(0, 1, 1, 32'h00880000, "R7");
    op(0, 0, 1, 32'h870D0019, "R4");
    op(0, 0, 1, 32'h000D0019, "R4");
    op(0, 0, 0, 0, "R4");
    op(0, 0, 1, 32'h070E0019, "R4");
    op(0, 0, 0, 0, "R4");
    // R7 address write filtering
    op(1, 3, 1, 32'h0000AAAA, "R7");
    op(1, 3, 0, 0, "R7");
    op(1, 2, 1, 32'h00000055, "R7");
    op(1, 5, 1, 32'h00000099, "R7");
    op(1, 6, 1, 32'h00000077, "R7");
    op(1, 4, 1, 32'h00000044, "R7");
    op(1, 5, 0, 0, "R7");
    // R10 out of range
    op(0, 4, 1, 32'hFFFFFFFF, "R10");
    op(0, 4, 0, 0, "R10");
    op(1, 20, 1, 32'h11111111, "R10");
    op(1, 20, 0, 0, "R10");
    op(3, 0, 0, 0, "R10");
    // R9 bypass refused while locked
    op(2, 0, 1, 32'h4, "R9");
    op(2, 0, 0, 0, "R9");
    do_reset();
    op(0, 0, 0, 0, "R1");
    // R9 bypass behaviour
    op(2, 0, 1, 32'h4, "R9");
    op(0, 0, 1, 32'h00000080, "R9");
    op(0, 0, 1, 32'h00000081, "R9");
    op(1, 0, 1, 32'h00000AB0, "R9");
    op(1, 0, 0, 0, "R9");
    op(2, 0, 1, 32'h0, "R9");
    op(2, 0, 1, 32'h4, "R9");
    op(0, 0, 1, 32'h00000083, "R4");
    op(0, 0, 0, 0, "R4");
    // R8 sticky guard bits
    op(2, 0, 1, 32'h1, "R8");
    op(2, 0, 1, 32'h0, "R8");
    op(2, 0, 1, 32'h2, "R8");
    op(2, 0, 1, 32'h0, "R8");
    op(2, 0, 0, 0, "R8");
    // R5 lockdown acceptance, R6 no scrub in lockdown
    op(0, 1, 1, 32'h02068581, "R5");
    op(0, 1, 0, 0, "R5_R6");
    op(0, 0, 1, 32'h00000087, "R5");
    op(0, 0, 1, 32'h00000083, "R5");
    op(0, 0, 0, 0, "R5");
    op(3, 0, 0, 0, "R11");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule